// File: doc/BRIEF.md
# Configurable-Frame Asynchronous Serial Receiver

This block takes one idle-high asynchronous serial line and recovers the data word carried by each frame. For each frame it presents the word, a one-cycle completion strobe, a parity-error flag and a framing-error flag. Bit timing comes from a divisor derived at elaboration from the system clock frequency and the baud rate, rounded to the nearest integer. The bit timer counts only while a frame is being received. It is restarted by a falling edge on the synchronized line and is held at zero at all other times. Every bit is sampled once, half a bit time into its slot.

Three run-time inputs set the frame shape: the data length (5 to 8 bits), the parity mode (none, odd, even, forced one, forced zero) and the stop length (half, one or two bit times). The receiver captures these inputs when it detects the start edge. It then uses the captured copy for the whole frame, so the inputs may change freely while a frame is in flight.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is asserted and after it is released, `rx_done`, `rx_data`, `par_err` and `frm_err` are all zero.
- R2: A frame starts only on a high-to-low transition of `rxd` after the line has passed through a 2-stage synchronizer. The bit counter stays at zero whenever no frame is in progress.
- R3: The divisor is DIV = round(CLK_HZ / BAUD_HZ). Let T0 be the first clock edge that sees `rxd` low. Each frame slot b (the start bit is slot 0) is sampled at edge T0 + 3 + b·DIV + DIV/2.
- R4: `len_sel` selects len_sel+5 data bits. The bits arrive least significant first and land in `rx_data[0]` upward. Unused upper bits of `rx_data` read 0.
- R5: `par_sel` encodes 0 none, 1 odd, 2 even, 3 forced one, 4 forced zero (5 to 7 act as none). Odd and even parity use the XOR reduction of the data bits. `par_err` is 1 when the received parity bit differs from the expected bit, and is always 0 when no parity bit is used.
- R6: `stop_sel` encodes 0 half, 1 one, 2 two stop bits (3 acts as one). A half stop bit is sampled DIV/4 into its slot. `frm_err` is 1 if any sampled stop bit is low.
- R7: If the start bit reads high at its sample point, the frame is dropped without a `rx_done` pulse and the receiver waits for a new falling edge.
- R8: Changing `len_sel`, `par_sel` or `stop_sel` after the start edge has no effect on the frame in progress.
- R9: `rx_done` is a one-cycle pulse on the edge after the final stop sample. `rx_data`, `par_err` and `frm_err` update only in that cycle and hold until the next pulse.
- R10: A new start bit that directly follows a half or single stop bit, with no idle gap, is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| len_sel | input | 2 | Data length select (bits = value + 5) |
| par_sel | input | 3 | Parity mode select |
| stop_sel | input | 2 | Stop length select |
| rx_data | output | 8 | Last received data word |
| rx_done | output | 1 | One-cycle frame completion strobe |
| par_err | output | 1 | Parity mismatch of last frame |
| frm_err | output | 1 | Low stop bit seen in last frame |

## Verification
The parity check and the stop-bit check of a single frame both report through the same completion strobe. A frame that carries a flipped parity bit and a low stop bit therefore raises both flags in one cycle. The bench sends such a frame with odd parity and two stop bits. It expects both flags set alongside the data word on the exact edge that its cycle model predicts. A second overlap is a start edge arriving just after the half-stop completion. Back-to-back frames with no idle gap probe this case, and the bench judges each frame's strobe cycle and word separately.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_ODD   = 3'd1,
      PAR_EVEN  = 3'd2,
      PAR_ONE   = 3'd3,
      PAR_ZERO  = 3'd4
   } par_mode_e;

   typedef enum logic [1:0] {
      STP_HALF = 2'd0,
      STP_ONE  = 2'd1,
      STP_TWO  = 2'd2
   } stop_mode_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

   function automatic par_mode_e decode_par(input logic [2:0] code);
      case (code)
         3'd1:    return PAR_ODD;
         3'd2:    return PAR_EVEN;
         3'd3:    return PAR_ONE;
         3'd4:    return PAR_ZERO;
         default: return PAR_NONE;
      endcase
   endfunction

   function automatic stop_mode_e decode_stop(input logic [1:0] code);
      case (code)
         2'd0:    return STP_HALF;
         2'd2:    return STP_TWO;
         default: return STP_ONE;
      endcase
   endfunction

   // data beyond the configured length is zero, so a full-width XOR is exact
   function automatic logic expected_par(input logic [7:0] word, input par_mode_e mode);
      case (mode)
         PAR_ODD:  return ~^word;
         PAR_EVEN: return ^word;
         PAR_ONE:  return 1'b1;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
   parameter int DIV = 16,
   parameter int CW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
   import uart_rx_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BAUD_HZ     = 115_200,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   input  logic [1:0] len_sel,
   input  logic [2:0] par_sel,
   input  logic [1:0] stop_sel,
   output logic [7:0] rx_data,
   output logic       rx_done,
   output logic       par_err,
   output logic       frm_err
);

   localparam int DIV   = (CLK_HZ + BAUD_HZ / 2) / BAUD_HZ;
   localparam int HALF  = DIV / 2;
   localparam int QUART = DIV / 4;
   localparam int CW    = $clog2(DIV);

   generate
      if (DIV < 8) begin : g_bad_div
         $error("uart_frame_rx: clock too slow for baud rate");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_frame_rx: at least two synchronizer stages needed");
      end
   endgenerate

   logic          line, line_q, fall;
   logic [CW-1:0] cnt;
   logic          busy, at_mid, at_quart, stop_tick;
   rx_state_e     state;
   logic [2:0]    bit_idx, last_idx;
   logic [7:0]    shreg;
   logic [1:0]    len_q;
   par_mode_e     par_q;
   stop_mode_e    stop_q;
   logic          second_stop, perr_acc, ferr_acc;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line;
   end

   assign fall = line_q & ~line;
   assign busy = (state != RX_IDLE);

   uart_rx_timer #(.DIV(DIV), .CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .cnt(cnt)
   );

   assign at_mid    = (cnt == CW'(HALF));
   assign at_quart  = (cnt == CW'(QUART));
   assign stop_tick = (stop_q == STP_HALF) ? at_quart : at_mid;
   assign last_idx  = 3'(len_q) + 3'd4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= RX_IDLE;
         bit_idx     <= '0;
         shreg       <= '0;
         len_q       <= '0;
         par_q       <= PAR_NONE;
         stop_q      <= STP_ONE;
         second_stop <= 1'b0;
         perr_acc    <= 1'b0;
         ferr_acc    <= 1'b0;
         rx_data     <= '0;
         rx_done     <= 1'b0;
         par_err     <= 1'b0;
         frm_err     <= 1'b0;
      end else begin
         rx_done <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (fall) begin
                  len_q       <= len_sel;
                  par_q       <= decode_par(par_sel);
                  stop_q      <= decode_stop(stop_sel);
                  shreg       <= '0;
                  bit_idx     <= '0;
                  second_stop <= 1'b0;
                  perr_acc    <= 1'b0;
                  ferr_acc    <= 1'b0;
                  state       <= RX_START;
               end
            end
            RX_START: begin
               if (at_mid) state <= line ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
               if (at_mid) begin
                  shreg[bit_idx] <= line;
                  if (bit_idx == last_idx)
                     state <= (par_q == PAR_NONE) ? RX_STOP : RX_PAR;
                  else
                     bit_idx <= bit_idx + 3'd1;
               end
            end
            RX_PAR: begin
               if (at_mid) begin
                  perr_acc <= (line != expected_par(shreg, par_q));
                  state    <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (stop_tick) begin
                  if (stop_q == STP_TWO && !second_stop) begin
                     second_stop <= 1'b1;
                     ferr_acc    <= ~line;
                  end else begin
                     rx_data <= shreg;
                     par_err <= perr_acc;
                     frm_err <= ferr_acc | ~line;
                     rx_done <= 1'b1;
                     state   <= RX_IDLE;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

endmodule

module uart_frame_rx_chk #(
   parameter int DIV = 16,
   parameter int CW  = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic [CW-1:0] cnt,
   input logic          line,
   input logic          line_q,
   input logic          rx_done,
   input logic [7:0]    rx_data,
   input logic          par_err,
   input logic          frm_err
);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data) |-> rx_done);

   a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(par_err) || !$stable(frm_err)) |-> rx_done);

   a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> !busy);

   a_r2_cnt_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> (cnt == '0));

   a_r2_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(line_q && !line));

   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DIV - 1));

endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DIV(DIV), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt), .line(line),
   .line_q(line_q), .rx_done(rx_done), .rx_data(rx_data),
   .par_err(par_err), .frm_err(frm_err)
);

// File: tb/tb_uart_frame_rx.sv
module tb_uart_frame_rx;

   localparam int CLK_HZ  = 1_600_000;
   localparam int BAUD_HZ = 100_000;
   localparam int DIV     = 16;
   localparam int HALF    = DIV / 2;
   localparam int QUART   = DIV / 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] len_sel = 2'd3;
   logic [2:0] par_sel = 3'd0;
   logic [1:0] stop_sel = 2'd1;
   logic [7:0] rx_data;
   logic       rx_done, par_err, frm_err;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;

   int    q_cyc[$];
   int    q_data[$];
   int    q_pe[$];
   int    q_fe[$];
   string q_tag[$];

   uart_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .len_sel(len_sel),
      .par_sel(par_sel), .stop_sel(stop_sel), .rx_data(rx_data),
      .rx_done(rx_done), .par_err(par_err), .frm_err(frm_err)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // cycle-by-cycle comparison against the expected completion queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (q_cyc.size() != 0 && q_cyc[0] == cyc) begin
            check({q_tag[0], " R3 R9 done"}, int'(rx_done), 1);
            check({q_tag[0], " R4 data"}, int'(rx_data), q_data[0]);
            check({q_tag[0], " R5 par_err"}, int'(par_err), q_pe[0]);
            check({q_tag[0], " R6 frm_err"}, int'(frm_err), q_fe[0]);
            void'(q_cyc.pop_front()); void'(q_data.pop_front());
            void'(q_pe.pop_front()); void'(q_fe.pop_front());
            void'(q_tag.pop_front());
         end else begin
            check("R9 R7 no done", int'(rx_done), 0);
         end
      end
   end

   task automatic send(input string tag, input logic [7:0] d, input int lenc,
                       input int parc, input int stopc, input bit bad_par,
                       input bit bad_stop, input bit chg_cfg, input int gap);
      int  n, has_par, bs, m, t0;
      logic [7:0] dm;
      logic pb;
      n       = lenc + 5;
      has_par = (parc >= 1 && parc <= 4) ? 1 : 0;
      bs      = 1 + n + has_par + ((stopc == 2) ? 1 : 0);
      m       = (stopc == 0) ? QUART : HALF;
      dm      = d & 8'((1 << n) - 1);
      case (parc)
         1: pb = ~^dm;
         2: pb = ^dm;
         3: pb = 1'b1;
         default: pb = 1'b0;
      endcase
      len_sel  = 2'(lenc);
      par_sel  = 3'(parc);
      stop_sel = 2'(stopc);
      rxd = 1'b0;
      t0 = cyc + 1;
      q_cyc.push_back(t0 + 3 + bs * DIV + m);
      q_data.push_back(int'(dm));
      q_pe.push_back((has_par != 0 && bad_par) ? 1 : 0);
      q_fe.push_back(bad_stop ? 1 : 0);
      q_tag.push_back(tag);
      repeat (DIV) @(negedge clk);
      if (chg_cfg) begin
         len_sel  = ~len_sel;
         par_sel  = 3'(parc + 1);
         stop_sel = 2'(stopc + 1);
      end
      for (int i = 0; i < n; i++) begin
         rxd = d[i];
         repeat (DIV) @(negedge clk);
      end
      if (has_par != 0) begin
         rxd = pb ^ bad_par;
         repeat (DIV) @(negedge clk);
      end
      rxd = ~bad_stop;
      repeat ((stopc == 0) ? HALF : DIV) @(negedge clk);
      if (stopc == 2) begin
         rxd = 1'b1;
         repeat (DIV) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   initial begin : watchdog
      wait (cyc >= 150_000);
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R1 data in reset", int'(rx_data), 0);
      check("R1 done in reset", int'(rx_done), 0);
      check("R1 flags in reset", int'({par_err, frm_err}), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check("R1 data after reset", int'(rx_data), 0);
      check("R2 idle line no frame", int'(rx_done), 0);

      send("R4 8N1",        8'hA5, 3, 0, 1, 0, 0, 0, 20);
      send("R4 7E1",        8'h5B, 2, 2, 1, 0, 0, 0, 20);
      send("R5 6O1",        8'h2C, 1, 1, 1, 0, 0, 0, 20);
      send("R6 5 one 2stp", 8'h13, 0, 3, 2, 0, 0, 0, 20);
      send("R6 8 zero half", 8'hFF, 3, 4, 0, 0, 0, 0, 20);
      send("R5 even bad",   8'h81, 3, 2, 1, 1, 0, 0, 20);
      send("R6 low stop",   8'h7E, 3, 0, 1, 0, 1, 0, 20);
      send("R5 R6 both",    8'hC3, 3, 1, 2, 1, 1, 0, 20);
      send("R5 one bad",    8'h0F, 2, 3, 1, 1, 0, 0, 20);

      // R7: short low pulse, start sample sees high
      rxd = 1'b0;
      repeat (3) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * DIV) @(negedge clk);
      send("R7 after glitch", 8'h3C, 3, 0, 1, 0, 0, 0, 20);

      send("R8 cfg change", 8'h96, 3, 2, 2, 0, 0, 1, 20);

      send("R10 b2b half a", 8'h11, 3, 0, 0, 0, 0, 0, 0);
      send("R10 b2b half b", 8'hEE, 3, 1, 0, 0, 0, 0, 0);
      send("R10 b2b one c",  8'h55, 1, 0, 1, 0, 0, 0, 0);
      send("R10 b2b one d",  8'h0A, 0, 2, 1, 0, 0, 0, 30);

      repeat (2 * DIV) @(negedge clk);
      check("R9 all frames completed", q_cyc.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule